// File: doc/BRIEF.md
# Lower-Part OR Approximate Adder

This block adds two WL-bit operands approximately to save area and delay. The operands are cut at a boundary LPL bits from the bottom. Below the boundary, each result bit is the OR of the two operand bits, and no carry ripples through that part. Above the boundary, an exact ripple-carry sub-adder of WL-LPL bits adds the upper operand bits. Its only carry-in is the AND of the top bit of each lower operand part. Setting LPL to zero removes the lower part, and the block becomes an exact adder.

The block is purely combinational and has no clock, no reset and no handshake. A result appears at the outputs as soon as the operands settle, so the surrounding pipeline registers its inputs and outputs. This is why no valid/ready rules apply. The bits are the same for unsigned and two's-complement operands. The caller reads the WL-bit sum as signed or unsigned. The carry-out has meaning only for unsigned use.

Top module: `orlow_adder`

## Requirements
- R1: Each result bit i with i < LPL equals op_a[i] OR op_b[i].
- R2: The result bits from LPL up to WL-1 equal the sum, modulo 2^(WL-LPL), of op_a[WL-1:LPL], op_b[WL-1:LPL] and the sub-adder carry-in.
- R3: When LPL > 0, the sub-adder carry-in is op_a[LPL-1] AND op_b[LPL-1]. Carries produced at lower positions never reach the upper part.
- R4: carry_out is the carry out of the most significant stage of the upper sub-adder.
- R5: With LPL = 0, {carry_out, sum} equals the exact op_a + op_b for every operand pair.
- R6: The bits of sum do not depend on whether the operands are signed. When two's-complement operands are given, sum read as a signed value follows R1 to R3.
- R7: When LPL > 0, the deviation {carry_out, sum} minus the exact (WL+1)-bit sum lies between -(2^(LPL-1) - 1) and +2^(LPL-1), inclusive.
- R8: Parameters must satisfy 0 <= LPL < WL. Any other setting stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WL | First operand |
| op_b | input | WL | Second operand |
| sum | output | WL | Approximate sum |
| carry_out | output | 1 | Carry out of the upper sub-adder |

## Verification
The bench targets the carry boundary. When both lower-part top bits are set, a design that drops the AND carry or takes it from the wrong bit gives an upper part one too small. When lower bits overlap elsewhere, a design that lets the lower part ripple gives an upper part one too large. A second instance with LPL=0 catches a generate branch that still forces a carry or leaves stale OR bits: its sum would differ from the exact sum. A third instance with LPL=WL-1 leaves a one-bit sub-adder and catches slicing errors at the edge. A pseudo-random sweep counts how many results differ from the exact sum and records the largest positive and negative deviations. A lower part that is mis-sized or mis-wired would push those deviations outside the R7 bounds.

// File: rtl/orlow_pkg.sv
package orlow_pkg;
  // Majority of three bits: the carry of one full-adder stage.
  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction
endpackage

// File: rtl/orlow_fa.sv
module orlow_fa
  import orlow_pkg::*;
(
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  always_comb begin
    s  = x ^ y ^ ci;
    co = maj3(x, y, ci);
  end
endmodule

// File: rtl/orlow_ripple.sv
module orlow_ripple #(
  parameter int W = 12
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout
);
  logic [W:0] chain;
  assign chain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_stage
    orlow_fa u_fa (
      .x (a[i]),
      .y (b[i]),
      .ci(chain[i]),
      .s (s[i]),
      .co(chain[i+1])
    );
  end

  assign cout = chain[W];

  logic [W:0] exact_v;
  always_comb begin
    exact_v = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    // R2
    ripple_exact_chk: assert ({cout, s} == exact_v);
  end
endmodule

// File: rtl/orlow_lower.sv
module orlow_lower #(
  parameter int L = 4
) (
  input  logic [L-1:0] a,
  input  logic [L-1:0] b,
  output logic [L-1:0] s,
  output logic         carry_up
);
  for (genvar i = 0; i < L; i++) begin : g_or
    assign s[i] = a[i] | b[i];
  end
  assign carry_up = a[L-1] & b[L-1];
endmodule

// File: rtl/orlow_adder.sv
module orlow_adder #(
  parameter int WL  = 16,
  parameter int LPL = 4
) (
  input  logic [WL-1:0] op_a,
  input  logic [WL-1:0] op_b,
  output logic [WL-1:0] sum,
  output logic          carry_out
);
  localparam int UW = WL - LPL;

  // R8
  if (LPL < 0 || LPL >= WL) begin : g_bad_param
    $error("orlow_adder: LPL must satisfy 0 <= LPL < WL");
  end

  logic          sub_cin;
  logic [UW-1:0] upper_s;

  if (LPL > 0) begin : g_lower
    logic [LPL-1:0] lower_s;
    orlow_lower #(.L(LPL)) u_lower (
      .a       (op_a[LPL-1:0]),
      .b       (op_b[LPL-1:0]),
      .s       (lower_s),
      .carry_up(sub_cin)
    );
    assign sum = {upper_s, lower_s};

    localparam int POS_MAX = 2 ** (LPL - 1);
    localparam int NEG_MAX = 2 ** (LPL - 1) - 1;
    logic signed [WL+1:0] dev;
    always_comb begin
      // R1
      lower_or_chk: assert (sum[LPL-1:0] == (op_a[LPL-1:0] | op_b[LPL-1:0]));
      // R3
      carry_in_chk: assert (sub_cin == (op_a[LPL-1] & op_b[LPL-1]));
      dev = $signed({1'b0, carry_out, sum}) - $signed({2'b00, op_a} + {2'b00, op_b});
      // R7
      dev_bound_chk: assert (int'(dev) <= POS_MAX && int'(dev) >= -NEG_MAX);
    end
  end else begin : g_exact
    assign sub_cin = 1'b0;
    assign sum     = upper_s;
    always_comb begin
      // R5
      exact_sum_chk: assert ({carry_out, sum} == ({1'b0, op_a} + {1'b0, op_b}));
    end
  end

  orlow_ripple #(.W(UW)) u_upper (
    .a   (op_a[WL-1:LPL]),
    .b   (op_b[WL-1:LPL]),
    .cin (sub_cin),
    .s   (upper_s),
    .cout(carry_out)
  );
endmodule

// File: tb/orlow_adder_test.sv
module orlow_adder_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;   // 125 MHz

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  // Main instance: WL=16, LPL=4
  logic [15:0] a4, b4, s4;
  logic        c4;
  orlow_adder #(.WL(16), .LPL(4)) uut (.op_a(a4), .op_b(b4), .sum(s4), .carry_out(c4));

  // Exact instance: WL=16, LPL=0
  logic [15:0] a0, b0, s0;
  logic        c0;
  orlow_adder #(.WL(16), .LPL(0)) uut_exact (.op_a(a0), .op_b(b0), .sum(s0), .carry_out(c0));

  // Edge instance: WL=8, LPL=7
  logic [7:0] a7, b7, s7;
  logic       c7;
  orlow_adder #(.WL(8), .LPL(7)) uut_edge (.op_a(a7), .op_b(b7), .sum(s7), .carry_out(c7));

  // Reference built from the requirements: OR below LPL, AND carry, exact upper add.
  function automatic longint gold(int wl, int lpl, longint a, longint b);
    longint lo, hi, cin;
    lo  = (a | b) & ((64'sd1 <<< lpl) - 1);
    cin = (lpl > 0) ? (((a >> (lpl - 1)) & (b >> (lpl - 1))) & 1) : 0;
    hi  = (a >> lpl) + (b >> lpl) + cin;
    return ((hi << lpl) | lo) & ((64'sd1 <<< (wl + 1)) - 1);
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(logic [15:0] a, logic [15:0] b);
    @(posedge clk);
    a4 = a; b4 = b; a0 = a; b0 = b;
    a7 = a[7:0]; b7 = b[7:0];
    @(negedge clk);
  endtask

  task automatic check_all(string req);
    check({req, " lpl4"}, {c4, s4}, gold(16, 4, a4, b4));
    check({req, " lpl0 R5"}, {c0, s0}, longint'(a0) + longint'(b0));
    check({req, " lpl7"}, {c7, s7}, gold(8, 7, a7, b7));
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    check("reset R5", {c0, s0}, 0);
    check("reset R1", {c4, s4}, 0);
  endtask

  task automatic t_lower_or;
    apply(16'h0005, 16'h0003);          // overlap on bit0 only; bit3 clear
    check("R1 lower or", s4[3:0], 4'h7);
    check("R3 no ripple", s4[15:4], 0);
    apply(16'h00F0, 16'h000F);
    check("R1 disjoint", s4, 16'h00FF);
    check_all("R1 mix");
  endtask

  task automatic t_carry_boundary;
    apply(16'h0008, 16'h0008);          // both lower MSBs set
    check("R3 and carry", s4, 16'h0018);
    apply(16'h0007, 16'h0007);          // lower overlap, MSBs clear
    check("R3 no carry", s4, 16'h0007);
    apply(16'h0FF8, 16'h0008);          // carry propagates through upper
    check("R2 upper ripple", s4, 16'h1008);
    check_all("R3 boundary");
  endtask

  task automatic t_carry_out;
    apply(16'hFFF8, 16'h0008);
    check("R4 carry out", c4, 1);
    check("R4 sum wrap", s4, 16'h0008);
    apply(16'h8000, 16'h7FF0);
    check("R4 no carry", c4, 0);
    check_all("R4");
  endtask

  task automatic t_signed;
    // -3 + -5 : 0xFFFD | 0xFFFB lower = 0xF, bit3 both set -> carry in
    apply(16'hFFFD, 16'hFFFB);
    check("R6 signed", s4, 16'hFFFF & gold(16, 4, 16'hFFFD, 16'hFFFB));
    check("R6 signed exact", s0, 16'hFFF8);
    apply(16'h0064, 16'hFF9C);          // 100 + -100
    check("R6 cancel exact", s0, 0);
    check_all("R6");
  endtask

  task automatic t_sweep;
    logic [31:0] lfsr = 32'hACE1_2468;
    int differ = 0;
    longint pos_max = 0, neg_max = 0;
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      apply(lfsr[15:0], lfsr[31:16]);
      check_all("R2 sweep");
      begin
        longint dev;
        dev = longint'({c4, s4}) - (longint'(a4) + longint'(b4));
        if (dev != 0) differ++;
        if (dev > pos_max) pos_max = dev;
        if (dev < neg_max) neg_max = dev;
        checks++;
        if (dev > 8 || dev < -7) begin
          errors++;
          $display("FAIL R7 deviation: actual=%0d expected=[-7,8]", dev);
        end
      end
    end
    $display("sweep: %0d of 3000 differ from exact, max +%0d, max %0d", differ, pos_max, neg_max);
  endtask

  task automatic t_extremes;
    apply(16'hFFFF, 16'hFFFF);
    check_all("R7 extreme");
    check("R7 max positive", longint'({c4, s4}) - 32'h1FFFE, 1);
    apply(16'h0008, 16'h000F);          // and = 8 -> dev = +8
    check("R7 top", longint'({c4, s4}) - 23, 8);
    apply(16'h0007, 16'h0007);          // and = 7, no carry -> dev = -7
    check("R7 bottom", longint'({c4, s4}) - 14, -7);
  endtask

  initial begin
    a4 = '0; b4 = '0; a0 = '0; b0 = '0; a7 = '0; b7 = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_reset_state();
    t_lower_or();
    t_carry_boundary();
    t_carry_out();
    t_signed();
    t_extremes();
    t_sweep();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule